// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a segment selection plus an offset into a linear address. It works in two modes. In the 16-bit mode with no protection, a segment value is moved up by four bit positions and the low 16 bits of the offset are added to it. The result is a 20-bit address, and the segment is always 64 KB long. In protected mode, the offset is added to the base address of a descriptor that is already cached. Before the address is released, the block checks that the segment is present and that the whole access lies inside the segment limit. The limit counts bytes or 4 KB pages, depending on a granularity flag.

A request is one cycle with `req_valid` high, carrying the mode, the segment value or the cached descriptor fields, the offset and the access width. One cycle later the block shows the result on its outputs. A good translation gives a one-cycle `lin_valid` pulse with the address. A bad one gives a fault code and no pulse. The block also reports the default operand size of the segment that was used.

Top module: `seg_xlate_top`

## Requirements
- R1: While reset is asserted and after it is released with no request, `lin_addr` is 0, `lin_valid` is 0, `fault_code` is 0 and `op32` is 0.
- R2: In 16-bit mode (`prot_mode`=0) a good request yields `lin_addr` = ((`seg_value` << 4) + `offset`[15:0]) mod 2^20. Bits 31:20 are zero.
- R3: In 16-bit mode the last byte touched is `offset` + `acc_size`, where `acc_size` is the byte count minus one (0..3), computed without wrap. If that last byte is above 0xFFFF, the block reports `fault_code` 1 (limit).
- R4: In protected mode a good request yields `lin_addr` = (`desc_base` + `offset`) mod 2^32.
- R5: With `desc_gran`=0 the effective limit is `desc_limit` in bytes. A request whose last byte exceeds it reports `fault_code` 1.
- R6: With `desc_gran`=1 the effective limit is `desc_limit` * 4096 + 4095. The last-byte comparison is made without wrap, so an access that runs past 0xFFFFFFFF is a limit fault.
- R7: In protected mode, `desc_present`=0 reports `fault_code` 2 (not present), even when the limit is also broken.
- R8: When a request faults, `lin_valid` stays 0 and `lin_addr` keeps its previous value.
- R9: The result appears exactly one cycle after the request. In a cycle that follows no request, `lin_valid` is 0, `fault_code` is 0, and `lin_addr` and `op32` hold their values.
- R10: On every request, `op32` takes `desc_dsize` in protected mode and 0 in 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one per cycle |
| prot_mode | input | 1 | 1 = protected mode, 0 = 16-bit shift-and-add mode |
| seg_value | input | 16 | Segment value for 16-bit mode |
| desc_base | input | 32 | Cached descriptor base |
| desc_limit | input | 20 | Cached descriptor limit |
| desc_gran | input | 1 | Limit unit: 1 = 4 KB pages, 0 = bytes |
| desc_present | input | 1 | Segment present flag |
| desc_dsize | input | 1 | Default operand size: 1 = 32-bit |
| offset | input | 32 | Effective address inside the segment |
| acc_size | input | 2 | Access width in bytes minus one |
| lin_addr | output | 32 | Translated linear address |
| lin_valid | output | 1 | One-cycle pulse for a good translation |
| fault_code | output | 2 | 0 none, 1 limit, 2 not present |
| op32 | output | 1 | Default operand size of the last request |

## Verification
The assertions watch the cycle-level rules on every cycle:
- a valid pulse never comes with a fault code;
- a cycle with no request leaves the outputs quiet and the address held;
- a missing segment always gives code 2;
- 16-bit mode never sets address bits above bit 19;
- 16-bit mode never reports a 32-bit operand size.

Only the bench scenarios can show that the arithmetic is right. These cover the exact sum in each mode and the 20-bit and 32-bit wraps. They also cover where the limit sits for each access width and each granularity, including the access that runs past the top of the 4 GB space under page granularity.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_ABSENT = 2'd2
  } xlat_fault_e;

endpackage

// File: rtl/seg_real_path.sv
// 16-bit mode path: segment shifted up and added to a 16-bit offset,
// fixed 64 KB limit checked against the last byte of the access.
module seg_real_path #(
  parameter int OFF_W    = 32,
  parameter int SEG_W    = 16,
  parameter int SZ_W     = 2,
  parameter int RM_SHIFT = 4
) (
  input  logic [SEG_W-1:0] seg_value,
  input  logic [OFF_W-1:0] offset,
  input  logic [SZ_W-1:0]  acc_size,
  output logic [OFF_W-1:0] addr,
  output logic             lim_fault
);
  localparam int RM_AW = SEG_W + RM_SHIFT;
  localparam int CW    = OFF_W + 1;

  logic [RM_AW-1:0] shifted_seg;
  logic [RM_AW-1:0] rm_sum;
  logic [CW-1:0]    last_byte;

  always_comb begin
    shifted_seg = {seg_value, {RM_SHIFT{1'b0}}};
    rm_sum      = shifted_seg + RM_AW'(offset[SEG_W-1:0]);
    addr        = OFF_W'(rm_sum);
    last_byte   = {1'b0, offset} + CW'(acc_size);
    lim_fault   = |last_byte[CW-1:SEG_W];
  end

endmodule

// File: rtl/seg_prot_path.sv
// Protected-mode path: descriptor base plus offset, presence and
// granularity-scaled limit check.
module seg_prot_path
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int LIM_W   = 20,
  parameter int SZ_W    = 2,
  parameter int GRAN_SH = 12
) (
  input  logic [OFF_W-1:0] desc_base,
  input  logic [LIM_W-1:0] desc_limit,
  input  logic             desc_gran,
  input  logic             desc_present,
  input  logic [OFF_W-1:0] offset,
  input  logic [SZ_W-1:0]  acc_size,
  output logic [OFF_W-1:0] addr,
  output xlat_fault_e      fault
);
  localparam int CW     = OFF_W + 1;
  localparam int ELIM_W = LIM_W + GRAN_SH;

  logic [CW-1:0] lim_bytes;
  logic [CW-1:0] lim_pages;
  logic [CW-1:0] eff_limit;
  logic [CW-1:0] last_byte;
  logic          over_limit;

  // Page-scaled limit: fill the low bits with ones, widen or clamp to CW.
  generate
    if (ELIM_W < CW) begin : g_pages_fit
      assign lim_pages = CW'({desc_limit, {GRAN_SH{1'b1}}});
    end else begin : g_pages_clamp
      logic [ELIM_W-1:0] wide_pages;
      assign wide_pages = {desc_limit, {GRAN_SH{1'b1}}};
      assign lim_pages  = (|wide_pages[ELIM_W-1:CW-1]) ?
                          {1'b0, {(CW-1){1'b1}}} : wide_pages[CW-1:0];
    end
  endgenerate

  assign lim_bytes = CW'(desc_limit);

  always_comb begin
    eff_limit  = desc_gran ? lim_pages : lim_bytes;
    last_byte  = {1'b0, offset} + CW'(acc_size);
    over_limit = last_byte > eff_limit;
    addr       = desc_base + offset;
    if (!desc_present) begin
      fault = FLT_ABSENT;
    end else if (over_limit) begin
      fault = FLT_LIMIT;
    end else begin
      fault = FLT_NONE;
    end
  end

endmodule

// File: rtl/seg_result_reg.sv
// Output stage: one register level between request and result.
module seg_result_reg
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OFF_W-1:0] sel_addr,
  input  xlat_fault_e      sel_fault,
  input  logic             sel_op32,
  output logic [OFF_W-1:0] lin_addr,
  output logic             lin_valid,
  output xlat_fault_e      fault_code,
  output logic             op32
);
  logic [OFF_W-1:0] addr_q,  addr_d;
  logic             vld_q,   vld_d;
  xlat_fault_e      flt_q,   flt_d;
  logic             op32_q,  op32_d;
  logic             addr_en;
  logic             op32_en;

  always_comb begin
    addr_en = req_valid && (sel_fault == FLT_NONE);
    op32_en = req_valid;
    addr_d  = addr_en ? sel_addr : addr_q;
    op32_d  = op32_en ? sel_op32 : op32_q;
    vld_d   = addr_en;
    flt_d   = req_valid ? sel_fault : FLT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      flt_q  <= FLT_NONE;
      op32_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      vld_q  <= vld_d;
      flt_q  <= flt_d;
      op32_q <= op32_d;
    end
  end

  assign lin_addr   = addr_q;
  assign lin_valid  = vld_q;
  assign fault_code = flt_q;
  assign op32       = op32_q;

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W    = 32,
  parameter int SEG_W    = 16,
  parameter int LIM_W    = 20,
  parameter int SZ_W     = 2,
  parameter int RM_SHIFT = 4,
  parameter int GRAN_SH  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             prot_mode,
  input  logic [SEG_W-1:0] seg_value,
  input  logic [OFF_W-1:0] desc_base,
  input  logic [LIM_W-1:0] desc_limit,
  input  logic             desc_gran,
  input  logic             desc_present,
  input  logic             desc_dsize,
  input  logic [OFF_W-1:0] offset,
  input  logic [SZ_W-1:0]  acc_size,
  output logic [OFF_W-1:0] lin_addr,
  output logic             lin_valid,
  output logic [1:0]       fault_code,
  output logic             op32
);
  logic [OFF_W-1:0] rm_addr;
  logic             rm_lim_fault;
  logic [OFF_W-1:0] pm_addr;
  xlat_fault_e      pm_fault;
  logic [OFF_W-1:0] sel_addr;
  xlat_fault_e      sel_fault;
  logic             sel_op32;
  xlat_fault_e      fault_q;

  seg_real_path #(
    .OFF_W(OFF_W), .SEG_W(SEG_W), .SZ_W(SZ_W), .RM_SHIFT(RM_SHIFT)
  ) u_real (
    .seg_value (seg_value),
    .offset    (offset),
    .acc_size  (acc_size),
    .addr      (rm_addr),
    .lim_fault (rm_lim_fault)
  );

  seg_prot_path #(
    .OFF_W(OFF_W), .LIM_W(LIM_W), .SZ_W(SZ_W), .GRAN_SH(GRAN_SH)
  ) u_prot (
    .desc_base    (desc_base),
    .desc_limit   (desc_limit),
    .desc_gran    (desc_gran),
    .desc_present (desc_present),
    .offset       (offset),
    .acc_size     (acc_size),
    .addr         (pm_addr),
    .fault        (pm_fault)
  );

  always_comb begin
    if (prot_mode) begin
      sel_addr  = pm_addr;
      sel_fault = pm_fault;
      sel_op32  = desc_dsize;
    end else begin
      sel_addr  = rm_addr;
      sel_fault = rm_lim_fault ? FLT_LIMIT : FLT_NONE;
      sel_op32  = 1'b0;
    end
  end

  seg_result_reg #(.OFF_W(OFF_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .sel_addr   (sel_addr),
    .sel_fault  (sel_fault),
    .sel_op32   (sel_op32),
    .lin_addr   (lin_addr),
    .lin_valid  (lin_valid),
    .fault_code (fault_q),
    .op32       (op32)
  );

  assign fault_code = fault_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int OFF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             prot_mode,
  input logic             desc_present,
  input logic [OFF_W-1:0] lin_addr,
  input logic             lin_valid,
  input logic [1:0]       fault_code,
  input logic             op32
);

  AST_VALID_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    lin_valid |-> fault_code == 2'd0);  // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!lin_valid && fault_code == 2'd0));  // R9

  AST_IDLE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(lin_addr) && $stable(op32)));  // R9

  AST_ABSENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_mode && !desc_present) |=>
      (fault_code == 2'd2 && !lin_valid));  // R7

  AST_SHORT_MODE_20BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_mode) |=> (!lin_valid || lin_addr[OFF_W-1:20] == '0));  // R2

  AST_SHORT_MODE_OP16: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_mode) |=> !op32);  // R10

  AST_FAULT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 2'd0) |-> $stable(lin_addr));  // R8

endmodule

bind seg_xlate_top seg_xlate_chk #(.OFF_W(OFF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .prot_mode    (prot_mode),
  .desc_present (desc_present),
  .lin_addr     (lin_addr),
  .lin_valid    (lin_valid),
  .fault_code   (fault_code),
  .op32         (op32)
);

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
module tb_seg_xlate_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        prot_mode;
  logic [15:0] seg_value;
  logic [31:0] desc_base;
  logic [19:0] desc_limit;
  logic        desc_gran;
  logic        desc_present;
  logic        desc_dsize;
  logic [31:0] offset;
  logic [1:0]  acc_size;
  logic [31:0] lin_addr;
  logic        lin_valid;
  logic [1:0]  fault_code;
  logic        op32;

  int checks = 0;
  int errors = 0;
  bit check_en = 1'b0;
  string cur_tag = "R1";

  // reference state
  logic [31:0] e_addr;
  logic        e_valid;
  logic [1:0]  e_fault;
  logic        e_op32;
  string       e_tag = "R1";

  always #10 clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_mode(prot_mode),
    .seg_value(seg_value), .desc_base(desc_base), .desc_limit(desc_limit),
    .desc_gran(desc_gran), .desc_present(desc_present), .desc_dsize(desc_dsize),
    .offset(offset), .acc_size(acc_size), .lin_addr(lin_addr),
    .lin_valid(lin_valid), .fault_code(fault_code), .op32(op32)
  );

  // Behavioural model, evaluated with wide integers.
  always @(posedge clk or negedge rst_n) begin
    longint last, lim, sum;
    if (!rst_n) begin
      e_addr <= '0; e_valid <= 1'b0; e_fault <= 2'd0; e_op32 <= 1'b0;
      e_tag <= "R1";
    end else begin
      e_tag <= cur_tag;
      if (req_valid) begin
        last = longint'(offset) + longint'(acc_size);
        e_op32 <= prot_mode ? desc_dsize : 1'b0;
        if (!prot_mode) begin
          if (last > 64'hFFFF) begin
            e_fault <= 2'd1; e_valid <= 1'b0;
          end else begin
            sum = longint'(seg_value) * 16 + longint'(offset % 65536);
            e_addr <= 32'(sum % 1048576); e_valid <= 1'b1; e_fault <= 2'd0;
          end
        end else begin
          lim = desc_gran ? longint'(desc_limit) * 4096 + 4095 : longint'(desc_limit);
          if (!desc_present) begin
            e_fault <= 2'd2; e_valid <= 1'b0;
          end else if (last > lim) begin
            e_fault <= 2'd1; e_valid <= 1'b0;
          end else begin
            sum = longint'(desc_base) + longint'(offset);
            e_addr <= 32'(sum % 64'h1_0000_0000); e_valid <= 1'b1; e_fault <= 2'd0;
          end
        end
      end else begin
        e_valid <= 1'b0; e_fault <= 2'd0;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (check_en) begin
      checks++;
      if (lin_addr !== e_addr || lin_valid !== e_valid ||
          fault_code !== e_fault || op32 !== e_op32) begin
        errors++;
        $display("FAIL %s: addr=%h valid=%b fault=%0d op32=%b expected addr=%h valid=%b fault=%0d op32=%b",
                 e_tag, lin_addr, lin_valid, fault_code, op32,
                 e_addr, e_valid, e_fault, e_op32);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    cur_tag = "R9";
    req_valid = 1'b0;
  endtask

  task automatic rm_req(string tag, logic [15:0] seg, logic [31:0] off, logic [1:0] sz);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1'b1; prot_mode = 1'b0;
    seg_value = seg; offset = off; acc_size = sz;
    desc_dsize = 1'b1;
  endtask

  task automatic pm_req(string tag, logic [31:0] base, logic [19:0] lim, logic g,
                        logic p, logic d, logic [31:0] off, logic [1:0] sz);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1'b1; prot_mode = 1'b1;
    desc_base = base; desc_limit = lim; desc_gran = g; desc_present = p;
    desc_dsize = d; offset = off; acc_size = sz;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; prot_mode = 1'b0; seg_value = '0;
    desc_base = '0; desc_limit = '0; desc_gran = 1'b0; desc_present = 1'b1;
    desc_dsize = 1'b0; offset = '0; acc_size = '0;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    checks++;
    if (lin_addr !== 32'd0 || lin_valid !== 1'b0 || fault_code !== 2'd0 || op32 !== 1'b0) begin
      errors++;
      $display("FAIL R1: addr=%h valid=%b fault=%0d op32=%b expected all zero",
               lin_addr, lin_valid, fault_code, op32);
    end
    rst_n = 1'b1;
    check_en = 1'b1;
    idle(); idle();

    // R2: shift-and-add, 20-bit wrap
    rm_req("R2", 16'h1234, 32'h0000_0010, 2'd0);
    rm_req("R2", 16'hFFFF, 32'h0000_0010, 2'd1);
    rm_req("R2", 16'hF000, 32'h0000_FFFF, 2'd0);
    rm_req("R10", 16'h0001, 32'h0, 2'd3);
    idle();
    // R3: 64 KB limit by last byte
    rm_req("R3", 16'h0100, 32'h0000_FFFD, 2'd2);
    rm_req("R3", 16'h0100, 32'h0000_FFFD, 2'd3);
    rm_req("R3", 16'h0100, 32'h0001_0000, 2'd0);
    rm_req("R8", 16'h0100, 32'hFFFF_FFFF, 2'd3);
    idle();
    // R4: base plus offset with 32-bit wrap
    pm_req("R4", 32'h0010_0000, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 32'h0000_1234, 2'd3);
    pm_req("R4", 32'hFFFF_FFF0, 20'hFFFFF, 1'b1, 1'b1, 1'b0, 32'h0000_0020, 2'd0);
    // R5: byte granularity
    pm_req("R5", 32'h0000_8000, 20'h00010, 1'b0, 1'b1, 1'b1, 32'h0000_0010, 2'd0);
    pm_req("R5", 32'h0000_8000, 20'h00010, 1'b0, 1'b1, 1'b1, 32'h0000_0010, 2'd1);
    pm_req("R5", 32'h0000_8000, 20'h00000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 2'd0);
    idle();
    // R6: page granularity
    pm_req("R6", 32'h0040_0000, 20'h00001, 1'b1, 1'b1, 1'b1, 32'h0000_1FFF, 2'd0);
    pm_req("R6", 32'h0040_0000, 20'h00001, 1'b1, 1'b1, 1'b1, 32'h0000_1FFD, 2'd2);
    pm_req("R6", 32'h0040_0000, 20'h00001, 1'b1, 1'b1, 1'b1, 32'h0000_1FFD, 2'd3);
    pm_req("R6", 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 2'd0);
    pm_req("R6", 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 2'd1);
    // R7: not present beats limit
    pm_req("R7", 32'h0000_1000, 20'hFFFFF, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 2'd0);
    pm_req("R7", 32'h0000_1000, 20'h00000, 1'b0, 1'b0, 1'b1, 32'h0000_0400, 2'd3);
    idle(); idle();
    // R10: operand size follows D only in protected mode
    pm_req("R10", 32'h0, 20'h0000F, 1'b0, 1'b1, 1'b1, 32'h0, 2'd0);
    rm_req("R10", 16'h0002, 32'h4, 2'd0);
    idle();

    // mixed pattern sweep
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        idle();
      end else if ($urandom_range(0, 1) == 0) begin
        rm_req("R3", 16'($urandom), ($urandom_range(0, 1) == 0) ? 32'($urandom_range(0, 65535))
               : 32'($urandom), 2'($urandom));
      end else begin
        pm_req("R6", $urandom, 20'($urandom_range(0, 31)), 1'($urandom),
               ($urandom_range(0, 7) != 0), 1'($urandom),
               32'($urandom_range(0, 200000)), 2'($urandom));
      end
    end
    idle(); idle();
    check_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule